// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

A single-port synchronous memory with a 36-bit word made of four 9-bit byte lanes. Commands (read or write, address, lane enables) are captured on a clock edge. Read data is placed in an output register and driven on the data bus one cycle after the command stage. A write is a late write: its data arrives on the bus in the cycle after the command. That data is parked in a pending-write register and is written into the array later. A read of the pending address returns the pending lanes merged over the array word. The data bus is kept on chip as a split pin set: an input path, an output path and a drive enable. The enable also obeys an asynchronous output-enable input and a sleep input.

The command stage is a small state machine with three states. ST_IDLE means no command is in the stage. ST_READ holds an accepted read. ST_WRITE holds an accepted write whose data is on the bus in the current cycle. From ST_IDLE or ST_WRITE, a live read goes to ST_READ and a live write goes to ST_WRITE. From ST_READ, a live read stays in ST_READ. A write from ST_READ is refused: it raises the protocol flag and goes to ST_IDLE. From any state, no command, or sleep, goes to ST_IDLE. Synchronous reset forces ST_IDLE. The depth is 2^ADDR_W words. ADDR_W is 18 for the full-size array and 6 by default for small instances.

Top module: `lw_sram`

## Requirements
- R1: Lane i (i = 0..3) covers bits [9i+8:9i] of the word. lanes_n[i] is active low. A write changes only the lanes whose enable is 0 and leaves the other lanes of that word unchanged.
- R2: A read command sampled at clock edge n drives dq_oe high with the addressed word on dq_o. This starts just after edge n+1 and lasts until edge n+2.
- R3: For a write command sampled at edge n, the write data is the value of dq_i sampled at edge n+1.
- R4: A read returns the most recent accepted write to its address, lane by lane. This includes a write issued in the cycle just before the read, whose data is still pending.
- R5: A write sampled at the edge right after an accepted read is refused. proto_err is high for the one cycle after that edge and the word is left unchanged. During the data cycle of an accepted write, dq_oe is never high.
- R6: While oe_n is high, dq_oe is low at once, with no clock edge needed. Lowering oe_n again restores the drive of registered read data.
- R7: While sleep is high, commands are ignored (a write there has no effect on the array) and dq_oe is low. Stored contents are kept.
- R8: In any cycle that does not follow an accepted read command, dq_oe is low.
- R9: Synchronous reset (rst high at an edge) clears the read pipeline, the protocol flag and the pending write. A write still pending at that edge is lost. Words already in the array are kept.
- R10: Pending data is written to the array on the next write or idle cycle, so back-to-back writes to any sequence of addresses all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Sleep request, active high |
| req | input | 1 | Command present this cycle |
| we | input | 1 | 1 = write, 0 = read (with req) |
| addr | input | ADDR_W | Word address |
| lanes_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 36 | Data bus as seen from the pins (write data) |
| dq_o | output | 36 | Data to drive on the bus |
| dq_oe | output | 1 | Bus drive enable (low = high impedance) |
| proto_err | output | 1 | Read-to-write turnaround violation flag |

## Verification
A stuck or wrong command-stage state shows up at the ports within two edges. A lost read leaves dq_oe low in the data cycle. A spurious one drives the bus in a dead or write-data cycle. A bad pending-register state, such as a stale valid bit, a wrong address compare or a wrong lane merge, is hidden until a later read of an affected word. The bench therefore reads every word and every lane mask both right after the write (through forwarding) and after the commit. A commit that escapes reset, or a write that escapes sleep or the turnaround check, is caught by re-reading the word it would have damaged.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } stage_e;
endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lanes_n,
    output stage_e            st,
    output logic [ADDR_W-1:0] st_addr,
    output logic [LANES-1:0]  st_en,
    output logic              proto_err
);
    stage_e st_nxt;
    logic   err_nxt;
    logic   cmd_live;

    assign cmd_live = req & ~sleep;

    // next-state decision for the command stage
    always_comb begin
        st_nxt  = ST_IDLE;
        err_nxt = 1'b0;
        unique case (st)
            ST_READ: begin
                if (cmd_live) begin
                    if (we) err_nxt = 1'b1;   // no dead cycle before the write
                    else    st_nxt  = ST_READ;
                end
            end
            ST_IDLE, ST_WRITE: begin
                if (cmd_live) st_nxt = we ? ST_WRITE : ST_READ;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nxt;
    end

    // registered outputs of the stage
    always_ff @(posedge clk) begin
        st_addr <= addr;
        st_en   <= ~lanes_n;
        if (rst) proto_err <= 1'b0;
        else     proto_err <= err_nxt;
    end
endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  stage_e            st,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [LANES-1:0]  st_en,
    input  logic [WORD_W-1:0] bus_in,
    input  logic [WORD_W-1:0] arr_word,
    output logic              cmt_we,
    output logic [ADDR_W-1:0] cmt_addr,
    output logic [LANES-1:0]  cmt_en,
    output logic [WORD_W-1:0] cmt_data,
    output logic [WORD_W-1:0] rd_word
);
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_en;
    logic [WORD_W-1:0] pend_data;
    logic              hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
        end else begin
            unique case (st)
                ST_WRITE: pend_valid <= 1'b1;
                ST_READ:  pend_valid <= pend_valid;
                ST_IDLE:  pend_valid <= 1'b0;
                default:  pend_valid <= 1'b0;
            endcase
        end
    end

    // late data is taken from the bus in the cycle after the write command
    always_ff @(posedge clk) begin
        if (st == ST_WRITE) begin
            pend_addr <= st_addr;
            pend_en   <= st_en;
            pend_data <= bus_in;
        end
    end

    // drain on any non-read cycle; reset discards the pending word
    assign cmt_we   = pend_valid & (st != ST_READ) & ~rst;
    assign cmt_addr = pend_addr;
    assign cmt_en   = pend_en;
    assign cmt_data = pend_data;

    assign hit = pend_valid & (pend_addr == st_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign rd_word[l*LANE_W +: LANE_W] = (hit && pend_en[l]) ?
            pend_data[l*LANE_W +: LANE_W] : arr_word[l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wen,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wen[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lanes_n,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] dq_i,
    output logic [WORD_W-1:0] dq_o,
    output logic              dq_oe,
    output logic              proto_err
);
    stage_e            st;
    logic [ADDR_W-1:0] st_addr;
    logic [LANES-1:0]  st_en;
    logic              cmt_we;
    logic [ADDR_W-1:0] cmt_addr;
    logic [LANES-1:0]  cmt_en;
    logic [WORD_W-1:0] cmt_data;
    logic [WORD_W-1:0] arr_word;
    logic [WORD_W-1:0] rd_word;
    logic              out_valid;
    logic [WORD_W-1:0] out_word;

    lw_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .sleep(sleep), .req(req), .we(we),
        .addr(addr), .lanes_n(lanes_n),
        .st(st), .st_addr(st_addr), .st_en(st_en), .proto_err(proto_err)
    );

    lw_sram_wbuf #(.ADDR_W(ADDR_W)) u_wbuf (
        .clk(clk), .rst(rst), .st(st), .st_addr(st_addr), .st_en(st_en),
        .bus_in(dq_i), .arr_word(arr_word),
        .cmt_we(cmt_we), .cmt_addr(cmt_addr), .cmt_en(cmt_en),
        .cmt_data(cmt_data), .rd_word(rd_word)
    );

    lw_sram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(cmt_we), .waddr(cmt_addr), .wen(cmt_en),
        .wdata(cmt_data), .raddr(st_addr), .rdata(arr_word)
    );

    // output register stage
    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= (st == ST_READ);
        out_word <= rd_word;
    end

    assign dq_o  = out_word;
    assign dq_oe = out_valid & ~oe_n & ~sleep;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
    import lw_sram_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   sleep,
    input logic   oe_n,
    input logic   req,
    input logic   we,
    input logic   dq_oe,
    input logic   proto_err,
    input stage_e st,
    input logic   out_valid
);
    AST_OE_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);                                            // R6
    AST_SLEEP_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dq_oe);                                           // R7
    AST_SLEEP_IGNORES_CMD: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (st == ST_IDLE));                                  // R7
    AST_TURNAROUND_FLAG: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READ && req && we && !sleep) |=> proto_err);       // R5
    AST_FLAGGED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> (st != ST_WRITE));                             // R5
    AST_NO_BUS_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRITE) |-> !dq_oe);                                // R5
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READ) |=> out_valid);                              // R2
    AST_BUS_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (st != ST_READ) |=> !dq_oe);                                 // R8
endmodule

bind lw_sram lw_sram_chk u_chk (
    .clk(clk), .rst(rst), .sleep(sleep), .oe_n(oe_n), .req(req), .we(we),
    .dq_oe(dq_oe), .proto_err(proto_err), .st(st), .out_valid(out_valid)
);

// File: tb/sim_lw_sram.sv
`timescale 1ns/100ps
module sim_lw_sram;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic        oe_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [3:0]  lanes_n = 4'hF;
    logic [35:0] dq_i = '0;
    logic [35:0] dq_o;
    logic        dq_oe;
    logic        proto_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [35:0] ref_mem [64];
    bit          prev_rd = 1'b0;
    bit          prev_wr = 1'b0;
    logic [35:0] prev_rd_exp = '0;
    logic [35:0] prev_wr_data = '0;

    always #2.5 clk = ~clk;

    lw_sram #(.ADDR_W(6)) u0 (
        .clk(clk), .rst(rst), .sleep(sleep), .req(req), .we(we),
        .addr(addr), .lanes_n(lanes_n), .oe_n(oe_n), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [35:0] merge(input logic [35:0] old_w, input logic [35:0] new_w,
                                          input logic [3:0] en);
        logic [35:0] r = old_w;
        for (int l = 0; l < 4; l++)
            if (en[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
        return r;
    endfunction

    function automatic logic [35:0] pat(input int a, input int k);
        logic [35:0] r;
        for (int l = 0; l < 4; l++) r[l*9 +: 9] = 9'(a * 7 + l * 113 + k * 29 + 1);
        return r;
    endfunction

    // one bus cycle: apply a command, sample just after the next rising edge
    task automatic step(input bit r, input bit w, input logic [5:0] a,
                        input logic [3:0] ln, input logic [35:0] d, input string tag);
        bit acc_rd, acc_wr, exp_err, exp_oe;
        logic [35:0] rd_exp;
        req = r; we = w; addr = a; lanes_n = ln;
        dq_i = prev_wr ? prev_wr_data : 36'h0;
        acc_rd  = r && !w && !sleep && !rst;
        exp_err = r && w && !sleep && !rst && prev_rd;
        acc_wr  = r && w && !sleep && !rst && !prev_rd;
        rd_exp  = ref_mem[a];
        if (acc_wr) ref_mem[a] = merge(ref_mem[a], d, ~ln);
        @(posedge clk);
        #2;
        exp_oe = prev_rd && !oe_n && !sleep && !rst;
        chk(dq_oe == exp_oe, tag, "bus drive", 36'(dq_oe), 36'(exp_oe));
        if (exp_oe) chk(dq_o == prev_rd_exp, tag, "read data", dq_o, prev_rd_exp);
        chk(proto_err == exp_err, tag, "turnaround flag", 36'(proto_err), 36'(exp_err));
        prev_rd = acc_rd; prev_rd_exp = rd_exp;
        prev_wr = acc_wr; prev_wr_data = d;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 6'd0, 4'hF, 36'h0, tag);
    endtask

    initial begin
        logic [35:0] keep;
        @(negedge clk);
        // R9: reset state
        idle("R9");
        idle("R9");
        rst = 1'b0;

        // R3 / R10: back-to-back writes across the whole array, then read all
        for (int a = 0; a < 64; a++) step(1'b1, 1'b1, 6'(a), 4'h0, pat(a, 0), "R10");
        idle("R3");
        idle("R3");
        for (int a = 0; a < 64; a++) step(1'b1, 1'b0, 6'(a), 4'hF, 36'h0, "R2");
        idle("R8");
        idle("R8");

        // R1 / R4: every lane mask, read immediately after (forwarded) and later
        for (int m = 0; m < 16; m++) begin
            step(1'b1, 1'b1, 6'd5, 4'(m), pat(m, 3), "R1");
            step(1'b1, 1'b0, 6'd5, 4'hF, 36'h0, "R4");
            idle("R4");
        end
        step(1'b1, 1'b0, 6'd5, 4'hF, 36'h0, "R1");
        idle("R1");
        // write then read of a different word while the pending one is held
        step(1'b1, 1'b1, 6'd6, 4'h5, pat(6, 9), "R4");
        step(1'b1, 1'b0, 6'd7, 4'hF, 36'h0, "R4");
        step(1'b1, 1'b0, 6'd6, 4'hF, 36'h0, "R4");
        idle("R4");
        idle("R10");

        // R5: write straight after a read is refused
        step(1'b1, 1'b0, 6'd3, 4'hF, 36'h0, "R5");
        step(1'b1, 1'b1, 6'd3, 4'h0, 36'h0F0F0F0F0, "R5");
        idle("R5");
        step(1'b1, 1'b0, 6'd3, 4'hF, 36'h0, "R5");
        idle("R5");

        // R6: output enable acts without a clock edge
        step(1'b1, 1'b0, 6'd7, 4'hF, 36'h0, "R6");
        req = 1'b0;
        @(posedge clk);
        #1;
        chk(dq_oe == 1'b1, "R6", "drive before release", 36'(dq_oe), 36'h1);
        chk(dq_o == ref_mem[7], "R6", "read data", dq_o, ref_mem[7]);
        oe_n = 1'b1;
        #1;
        chk(dq_oe == 1'b0, "R6", "released mid-cycle", 36'(dq_oe), 36'h0);
        oe_n = 1'b0;
        #0.2;
        chk(dq_oe == 1'b1, "R6", "drive restored", 36'(dq_oe), 36'h1);
        @(negedge clk);
        prev_rd = 1'b0; prev_wr = 1'b0;
        oe_n = 1'b1;
        step(1'b1, 1'b0, 6'd7, 4'hF, 36'h0, "R6");
        idle("R6");
        oe_n = 1'b0;

        // R7: sleep ignores commands and keeps contents
        sleep = 1'b1;
        step(1'b1, 1'b1, 6'd4, 4'h0, 36'h123456789, "R7");
        idle("R7");
        step(1'b1, 1'b0, 6'd4, 4'hF, 36'h0, "R7");
        idle("R7");
        sleep = 1'b0;
        step(1'b1, 1'b0, 6'd4, 4'hF, 36'h0, "R7");
        sleep = 1'b1;
        idle("R7");
        sleep = 1'b0;
        step(1'b1, 1'b0, 6'd4, 4'hF, 36'h0, "R7");
        idle("R7");

        // R9: reset drops a pending write but keeps committed words
        keep = ref_mem[9];
        step(1'b1, 1'b1, 6'd9, 4'h0, 36'hABCDE1234, "R9");
        idle("R9");
        rst = 1'b1;
        idle("R9");
        rst = 1'b0;
        ref_mem[9] = keep;
        step(1'b1, 1'b1, 6'd20, 4'h0, 36'h5A5A5A5A5, "R9");
        idle("R9");
        idle("R9");
        rst = 1'b1;
        idle("R9");
        rst = 1'b0;
        step(1'b1, 1'b0, 6'd9, 4'hF, 36'h0, "R9");
        step(1'b1, 1'b0, 6'd20, 4'hF, 36'h0, "R9");
        idle("R9");
        idle("R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule